// File: doc/BRIEF.md
# Interleaved ADC Gain and Offset Calibrator

This block sits behind a four-way time-interleaved converter. The sub-converters take turns, so their 8-bit samples arrive in rotation, each with a strobe and a 2-bit lane tag. Each lane has its own gain error and offset error. The block keeps a separate offset correction and gain correction for every lane, exposes both to the analog front end, and applies them digitally to produce a corrected 8-bit stream one cycle after each input sample.

During calibration the converter input carries a zero-mean Gaussian test signal of known power. While `cal_i` is high, each arriving sample drives two unsupervised loops on its own lane. The offset loop integrates the distance between the sample and the current offset, which pulls the offset toward the lane's mean. The gain loop integrates the difference between a reference power and the squared corrected sample, which pulls the corrected power toward the reference. When `cal_i` is low the loops freeze, and the frozen values are still applied. A per-lane settled flag reports when both loop steps have stayed small for a run of updates. A sticky flag reports a break in the lane rotation.

Top module: `tiadc_cal`

## Requirements
- R1: After reset, every gain correction is 0x4000 (1.0 in unsigned Q2.14), every offset correction is 0 (signed, 14 bits, 6 fractional bits), and `y_valid_o`, `y_o`, `y_ch_o`, `settled_o` and `seq_err_o` are all zero.
- R2: A sample x on lane c with `cal_i` high first forms d = x·64 − off[c]. It then updates the offset as off[c] += d >>> K_OFF, where >>> is an arithmetic (floor) shift.
- R3: On the same update, t = (g[c]·d) >>> 14 and e = P_REF − ((t·t) >>> 8), with P_REF in code² units carrying 4 fractional bits. The gain becomes g[c] + (e >>> K_GAIN), clamped to the range 0 to 0xFFFF.
- R4: An update changes only the correction words of the tagged lane. The other lanes hold their values.
- R5: While `cal_i` is low, no correction word changes, whatever samples arrive.
- R6: Every valid input produces `y_valid_o` high on the next cycle, with `y_ch_o` equal to the input tag and `y_o` = round((g[c]·d) / 2^20). Rounding adds 2^19 and then takes an arithmetic shift. The value uses the corrections as they stood before that sample's own update.
- R7: A corrected value above 127 is output as 127, and one below −128 is output as −128.
- R8: The expected tag starts at 0 and becomes (c+1) mod 4 after each valid sample. A valid sample whose tag differs from the expected tag sets `seq_err_o`, which stays set until reset.
- R9: A lane's counter increments on each update where both |e >>> K_GAIN| and |d >>> K_OFF| are below STEP_THR, and it clears on any other update. `settled_o[c]` is high while the counter has reached SETTLE_N. The flag can only rise on an update of that lane.
- R10: A cycle with `valid_i` low produces `y_valid_o` low on the next cycle and leaves all corrections and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_i | input | 1 | Loops update while high, frozen while low |
| valid_i | input | 1 | Input sample strobe |
| ch_i | input | 2 | Lane tag of the input sample |
| x_i | input | 8 | Raw sample, two's complement |
| y_valid_o | output | 1 | Corrected sample strobe |
| y_ch_o | output | 2 | Lane tag of the corrected sample |
| y_o | output | 8 | Corrected sample, two's complement, saturated |
| gain_o | output | 64 | Gain corrections, lane i in bits [16i+15:16i], unsigned Q2.14 |
| off_o | output | 56 | Offset corrections, lane i in bits [14i+13:14i], signed, 6 fractional bits |
| settled_o | output | 4 | Per-lane settled flags |
| seq_err_o | output | 1 | Sticky lane rotation error |

## Verification
The bench builds the block with K_OFF=4, K_GAIN=10, STEP_THR=20 and SETTLE_N=32, keeping P_REF at 16384. The short shifts make each loop move by many LSBs per update. A run of near-zero samples then settles all four lanes within about a hundred updates per lane. A long stretch of one-code samples drives the gain into its upper clamp within a few thousand updates per lane. With a gain of four, modest inputs saturate the corrected output in both directions.

// File: rtl/tiadc_cal_pkg.sv
`timescale 1ns/1ps
package tiadc_cal_pkg;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 14;
  localparam int OFF_FRAC  = 6;
  localparam int PWR_FRAC  = 4;
  localparam int PWR_SH    = 2*OFF_FRAC - PWR_FRAC;
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;
endpackage

// File: rtl/tiadc_seq.sv
`timescale 1ns/1ps
module tiadc_seq #(
  parameter int NUM_CH = 4,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [CW-1:0] ch_i,
  output logic          err_o
);
  logic [CW-1:0] exp_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      err_q <= 1'b0;
    end else if (valid_i) begin
      err_q <= err_q | (ch_i != exp_q);
      exp_q <= (ch_i == CW'(NUM_CH-1)) ? '0 : ch_i + CW'(1);
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/tiadc_corr.sv
`timescale 1ns/1ps
module tiadc_corr
  import tiadc_cal_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int K_OFF    = 8,
  parameter int K_GAIN   = 12,
  parameter int P_REF    = 16384,
  parameter int STEP_THR = 4,
  localparam int OFF_W = DATA_W + OFF_FRAC
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic        [GAIN_W-1:0] gain_i,
  input  logic signed [OFF_W-1:0]  off_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic        [GAIN_W-1:0] gain_nx_o,
  output logic signed [OFF_W-1:0]  off_nx_o,
  output logic                     quiet_o
);
  localparam int D_W = OFF_W + 1;
  localparam int P_W = GAIN_W + 1 + D_W;
  localparam int S_W = 2 * P_W;
  localparam int RSH = GAIN_FRAC + OFF_FRAC;
  localparam logic signed [P_W-1:0] HALF = P_W'(1) << (RSH-1);
  localparam logic signed [P_W-1:0] YMAX = P_W'(2**(DATA_W-1) - 1);
  localparam logic signed [P_W-1:0] YMIN = -P_W'(2**(DATA_W-1));
  localparam logic signed [S_W-1:0] PREF = S_W'(P_REF);
  localparam logic signed [S_W-1:0] GMAX = S_W'(2**GAIN_W - 1);
  localparam logic signed [S_W-1:0] THR_G = S_W'(STEP_THR);
  localparam logic signed [D_W-1:0] THR_O = D_W'(STEP_THR);

  logic signed [OFF_W-1:0] xq;
  logic signed [D_W-1:0]   d, doff, osum;
  logic signed [P_W-1:0]   gs, prod, ry, t;
  logic signed [S_W-1:0]   sq, e, dg, gsum;

  always_comb begin
    xq   = $signed({x_i, {OFF_FRAC{1'b0}}});
    d    = D_W'(xq) - D_W'(off_i);
    gs   = P_W'($signed({1'b0, gain_i}));
    prod = P_W'(d) * gs;

    // corrected sample, round half up then saturate
    ry = (prod + HALF) >>> RSH;
    if (ry > YMAX)      y_o = YMAX[DATA_W-1:0];
    else if (ry < YMIN) y_o = YMIN[DATA_W-1:0];
    else                y_o = ry[DATA_W-1:0];

    // offset integrator
    doff     = d >>> K_OFF;
    osum     = D_W'(off_i) + doff;
    off_nx_o = osum[OFF_W-1:0];

    // power-error gain integrator
    t    = prod >>> GAIN_FRAC;
    sq   = (S_W'(t) * S_W'(t)) >>> PWR_SH;
    e    = PREF - sq;
    dg   = e >>> K_GAIN;
    gsum = dg + S_W'(gs);
    if (gsum < 0)         gain_nx_o = '0;
    else if (gsum > GMAX) gain_nx_o = '1;
    else                  gain_nx_o = gsum[GAIN_W-1:0];

    quiet_o = (dg < THR_G) && (dg > -THR_G) && (doff < THR_O) && (doff > -THR_O);
  end
endmodule

// File: rtl/tiadc_lane.sv
`timescale 1ns/1ps
module tiadc_lane
  import tiadc_cal_pkg::*;
#(
  parameter int OFF_W    = 14,
  parameter int SETTLE_N = 256,
  localparam int CNT_W = $clog2(SETTLE_N + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic                    quiet_i,
  input  logic [GAIN_W-1:0]       gain_nx_i,
  input  logic signed [OFF_W-1:0] off_nx_i,
  output logic [GAIN_W-1:0]       gain_o,
  output logic signed [OFF_W-1:0] off_o,
  output logic                    settled_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= GAIN_ONE;
      off_o  <= '0;
      cnt_q  <= '0;
    end else if (upd_i) begin
      gain_o <= gain_nx_i;
      off_o  <= off_nx_i;
      if (!quiet_i)                       cnt_q <= '0;
      else if (cnt_q != CNT_W'(SETTLE_N)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign settled_o = (cnt_q == CNT_W'(SETTLE_N));
endmodule

// File: rtl/tiadc_cal.sv
`timescale 1ns/1ps
module tiadc_cal
  import tiadc_cal_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 8,
  parameter int K_OFF    = 8,
  parameter int K_GAIN   = 12,
  parameter int P_REF    = 16384,
  parameter int STEP_THR = 4,
  parameter int SETTLE_N = 256,
  localparam int CW    = $clog2(NUM_CH),
  localparam int OFF_W = DATA_W + OFF_FRAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cal_i,
  input  logic                     valid_i,
  input  logic [CW-1:0]            ch_i,
  input  logic [DATA_W-1:0]        x_i,
  output logic                     y_valid_o,
  output logic [CW-1:0]            y_ch_o,
  output logic [DATA_W-1:0]        y_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [NUM_CH*OFF_W-1:0]  off_o,
  output logic [NUM_CH-1:0]        settled_o,
  output logic                     seq_err_o
);
  logic [GAIN_W-1:0]       gain_q [NUM_CH];
  logic signed [OFF_W-1:0] off_q  [NUM_CH];
  logic [GAIN_W-1:0]       gain_nx;
  logic signed [OFF_W-1:0] off_nx;
  logic signed [DATA_W-1:0] y_c;
  logic                    quiet;

  tiadc_corr #(
    .DATA_W(DATA_W), .K_OFF(K_OFF), .K_GAIN(K_GAIN),
    .P_REF(P_REF), .STEP_THR(STEP_THR)
  ) u_corr (
    .x_i      ($signed(x_i)),
    .gain_i   (gain_q[ch_i]),
    .off_i    (off_q[ch_i]),
    .y_o      (y_c),
    .gain_nx_o(gain_nx),
    .off_nx_o (off_nx),
    .quiet_o  (quiet)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    tiadc_lane #(.OFF_W(OFF_W), .SETTLE_N(SETTLE_N)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (valid_i & cal_i & (ch_i == CW'(i))),
      .quiet_i  (quiet),
      .gain_nx_i(gain_nx),
      .off_nx_i (off_nx),
      .gain_o   (gain_q[i]),
      .off_o    (off_q[i]),
      .settled_o(settled_o[i])
    );
    assign gain_o[i*GAIN_W +: GAIN_W] = gain_q[i];
    assign off_o[i*OFF_W +: OFF_W]    = off_q[i];
  end

  tiadc_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .ch_i   (ch_i),
    .err_o  (seq_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_valid_o <= 1'b0;
      y_ch_o    <= '0;
      y_o       <= '0;
    end else begin
      y_valid_o <= valid_i;
      if (valid_i) begin
        y_ch_o <= ch_i;
        y_o    <= y_c;
      end
    end
  end
endmodule

// File: rtl/tiadc_cal_chk.sv
`timescale 1ns/1ps
module tiadc_cal_chk
  import tiadc_cal_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(NUM_CH),
  localparam int OFF_W = DATA_W + OFF_FRAC
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cal_i,
  input logic                     valid_i,
  input logic [CW-1:0]            ch_i,
  input logic                     y_valid_o,
  input logic [CW-1:0]            y_ch_o,
  input logic [NUM_CH*GAIN_W-1:0] gain_o,
  input logic [NUM_CH*OFF_W-1:0]  off_o,
  input logic [NUM_CH-1:0]        settled_o,
  input logic                     seq_err_o
);
  // R5
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_i |=> ($stable(gain_o) && $stable(off_o)));

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (y_valid_o && (y_ch_o == $past(ch_i))));

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!y_valid_o && $stable(settled_o) && $stable(seq_err_o)));

  // R8
  seq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    // R4
    lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(valid_i && cal_i && (ch_i == CW'(i))) |=>
        ($stable(gain_o[i*GAIN_W +: GAIN_W]) && $stable(off_o[i*OFF_W +: OFF_W])));

    // R9
    settle_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(settled_o[i]) |-> $past(valid_i && cal_i && (ch_i == CW'(i))));
  end
endmodule

bind tiadc_cal tiadc_cal_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cal_i    (cal_i),
  .valid_i  (valid_i),
  .ch_i     (ch_i),
  .y_valid_o(y_valid_o),
  .y_ch_o   (y_ch_o),
  .gain_o   (gain_o),
  .off_o    (off_o),
  .settled_o(settled_o),
  .seq_err_o(seq_err_o)
);

// File: tb/tiadc_cal_test.sv
`timescale 1ns/1ps
module tiadc_cal_test;
  localparam int NCH = 4;
  localparam int KO = 4;
  localparam int KG = 10;
  localparam int PREF = 16384;
  localparam int THR = 20;
  localparam int SN = 32;

  logic clk = 0, rst_n = 0, cal = 0, valid = 0;
  logic [1:0] ch = 0;
  logic [7:0] x = 0;
  logic y_valid, seq_err;
  logic [1:0] y_ch;
  logic [7:0] y;
  logic [63:0] gain;
  logic [55:0] off;
  logic [3:0] settled;

  int checks = 0, errors = 0;
  bit done = 0;
  longint mg[NCH], mo[NCH];
  int mc[NCH];
  bit merr;
  int mexp, nxt;

  tiadc_cal #(.NUM_CH(NCH), .DATA_W(8), .K_OFF(KO), .K_GAIN(KG), .P_REF(PREF),
              .STEP_THR(THR), .SETTLE_N(SN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cal_i(cal), .valid_i(valid), .ch_i(ch), .x_i(x),
    .y_valid_o(y_valid), .y_ch_o(y_ch), .y_o(y), .gain_o(gain), .off_o(off),
    .settled_o(settled), .seq_err_o(seq_err));

  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lane_off(int i);
    return longint'($signed(off[i*14 +: 14]));
  endfunction

  task automatic check_state();
    for (int i = 0; i < NCH; i++) begin
      chk(gain[i*16 +: 16] == 16'(mg[i]), "R3 gain", longint'(gain[i*16 +: 16]), mg[i]);
      chk(lane_off(i) == mo[i], "R2 offset", lane_off(i), mo[i]);
      chk(settled[i] == (mc[i] == SN), "R9 settled", longint'(settled[i]), longint'(mc[i] == SN));
    end
    chk(seq_err == merr, "R8 seq_err", longint'(seq_err), longint'(merr));
  endtask

  // starts and ends at a falling edge
  task automatic step(bit v, int xv, int c, bit cl);
    longint d, prod, ry, t, e, dg, doff, gn;
    valid = v; x = 8'(xv); ch = 2'(c); cal = cl;
    ry = 0;
    if (v) begin
      d = longint'(xv) * 64 - mo[c];
      prod = mg[c] * d;
      ry = (prod + (64'sd1 <<< 19)) >>> 20;
      if (ry > 127) ry = 127;
      if (ry < -128) ry = -128;
      if (cl) begin
        t = prod >>> 14;
        e = longint'(PREF) - ((t * t) >>> 8);
        dg = e >>> KG;
        doff = d >>> KO;
        gn = mg[c] + dg;
        if (gn < 0) gn = 0;
        if (gn > 65535) gn = 65535;
        if (dg < THR && dg > -THR && doff < THR && doff > -THR) begin
          if (mc[c] < SN) mc[c]++;
        end else mc[c] = 0;
        mg[c] = gn;
        mo[c] = mo[c] + doff;
      end
      if (c != mexp) merr = 1;
      mexp = (c + 1) % NCH;
    end
    @(negedge clk);
    chk(y_valid == v, "R6/R10 y_valid", longint'(y_valid), longint'(v));
    if (v) begin
      chk(longint'($signed(y)) == ry, "R6/R7 y", longint'($signed(y)), ry);
      chk(y_ch == 2'(c), "R6 y_ch", longint'(y_ch), longint'(c));
    end
    check_state();
  endtask

  task automatic send(int xv, bit cl);
    step(1, xv, nxt, cl);
    nxt = (nxt + 1) % NCH;
  endtask

  function automatic int gauss();
    return int'($urandom_range(0, 40)) + int'($urandom_range(0, 40)) +
           int'($urandom_range(0, 40)) + int'($urandom_range(0, 40)) - 80;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NCH; i++) begin mg[i] = 16384; mo[i] = 0; mc[i] = 0; end
    merr = 0; mexp = 0; nxt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(y_valid == 0 && y == 0 && y_ch == 0, "R1 outputs", longint'(y), 0);
    chk(gain == {4{16'h4000}}, "R1 gain", longint'(gain[15:0]), 16384);
    chk(off == '0 && settled == 0 && seq_err == 0, "R1 off/flags", longint'(settled), 0);
    rst_n = 1;
    @(negedge clk);

    // R5/R6: frozen loops, unity correction passes samples through
    for (int n = 0; n < 40; n++) send(gauss(), 0);
    chk(gain == {4{16'h4000}} && off == '0, "R5 frozen", longint'(gain[15:0]), 16384);

    // R2/R3/R4/R10: calibrating on random samples with idle gaps
    for (int n = 0; n < 800; n++) begin
      if ($urandom_range(0, 5) == 0) step(0, int'($urandom_range(0, 255)), int'($urandom_range(0, 3)), 1);
      else send(gauss(), 1);
    end

    // R9: near-zero input settles every lane
    for (int n = 0; n < 400; n++) send(0, 1);
    chk(settled == 4'hf, "R9 all settled", longint'(settled), 15);
    while (nxt != 0) send(0, 1);
    send(127, 1);
    chk(settled[0] == 0, "R9 spike clears lane 0", longint'(settled[0]), 0);
    chk(settled[3:1] == 3'b111, "R4 other lanes keep settled", longint'(settled[3:1]), 7);

    // R8: rotation skip
    while (nxt != 0) send(0, 0);
    chk(seq_err == 0, "R8 no error yet", longint'(seq_err), 0);
    send(3, 0);
    nxt = 2;
    send(3, 0);
    chk(seq_err == 1, "R8 skip flagged", longint'(seq_err), 1);
    for (int n = 0; n < 8; n++) send(gauss(), 0);
    chk(seq_err == 1, "R8 sticky", longint'(seq_err), 1);

    // R3 boundary: gain driven into its upper clamp
    for (int n = 0; n < 17200; n++) send(1, 1);
    chk(gain == {4{16'hffff}}, "R3 upper clamp", longint'(gain[15:0]), 65535);

    // R7: saturation both ways with gain near 4
    send(100, 0);
    chk($signed(y) == 127, "R7 positive saturation", longint'($signed(y)), 127);
    send(-100, 0);
    chk($signed(y) == -128, "R7 negative saturation", longint'($signed(y)), -128);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule